// File: doc/BRIEF.md
# Multi-Zone External Memory Bus Master

This block connects a processor core to asynchronous external memories and peripherals. The core presents a wide word address with a request flag. The block decodes that address into one of five external windows. It asserts the chip-select pin that belongs to the window and drives the address offset inside the window onto a 19-bit pin bus. It then runs a read or write strobe through three phases: setup (lead), strobe (active) and hold (trail). The length of each phase is counted in system clocks and set separately for each window. An address that falls outside every window is refused with an error acknowledge, and no pin moves.

Five windows share three chip-select pins: two pairs of windows each share one pin and the middle window has a pin of its own. Each window has one timing word. It holds the three phase lengths, a bit that doubles all three, and a bit that lets an external ready line stretch the strobe phase. The core can write and read these timing words through a small configuration port. The 16-bit data pins are a split output/input/enable triple, and the tri-state pad sits outside the block. The core holds its request until a single-cycle done pulse comes back.

Top module: `xbz_bus_master`

## Requirements
- R1: Window index, word range and chip-select pin: index 0 covers 0x002000-0x003FFF (pin 0); index 1 covers 0x004000-0x005FFF (pin 0); index 2 covers 0x080000-0x0FFFFF (pin 1); index 3 covers 0x100000-0x17FFFF (pin 2); index 4 covers 0x3FC000-0x3FFFFF (pin 2). Chip selects are active low, and during an access `ext_addr` carries the address minus the window base.
- R2: A request whose address lies in no window completes with `req_done` and `req_err` high together. No chip select or strobe is asserted.
- R3: An access first holds the chip select low with both strobes high for the lead count. It then holds one strobe low for the active count, then keeps the chip select low with strobes high for the trail count. A field value of zero counts as one clock.
- R4: When a window's double bit is set, the lead, active and trail durations of that window are each twice the R3 value.
- R5: When a window's ready-enable bit is set, the active phase lasts until the first active cycle that is at least the programmed count and in which `ext_ready` is high. When the bit is clear, `ext_ready` has no effect on any phase length.
- R6: `ext_data_oe` is high only during the active and trail phases of a write, and `ext_data_o` then carries the request's write data. Reads and idle cycles leave it low.
- R7: Read data is the value on `ext_data_i` in the last active cycle. It is presented on `req_rdata` while `req_done` is high.
- R8: `req_done` is high for exactly one cycle per request, and all chip selects are high in that cycle, so consecutive accesses are separated by at least one cycle with no chip select.
- R9: At most one chip-select pin is low at a time, the two strobes are never low together, and a strobe is only low while a chip select is low.
- R10: Timing word layout (default widths): bits [1:0] lead, [4:2] active, [6:5] trail, [7] ready-enable, [8] double. `cfg_rdata` returns the word of `cfg_idx` one clock later. An access uses the word latched when it was accepted, so a write made during an access takes effect from the next access.
- R11: After reset every timing word is 0x02E (lead 2, active 3, trail 1, ready off, double off), all chip selects and strobes are high, the data enable is low and no done is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Core word address |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Address hit no window (valid with done) |
| req_rdata | output | 16 | Read data (valid with done) |
| cfg_en | input | 1 | Timing word write enable |
| cfg_idx | input | 3 | Window index for write and readback |
| cfg_wdata | input | 9 | Timing word to write |
| cfg_rdata | output | 9 | Registered readback of the selected word |
| ext_addr | output | 19 | Offset within the selected window |
| ext_cs_n | output | 3 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_data_o | output | 16 | Write data toward the pins |
| ext_data_oe | output | 1 | Pad drive enable for the data pins |
| ext_data_i | input | 16 | Data from the pins |
| ext_ready | input | 1 | External ready, used where enabled |

## Verification
The main sweep runs every window with lead values 0, 1 and 3, active values 0, 2 and 7, trail values 1 and 3, both settings of the double bit, and both directions. It targets the first word, the last word and an interior word of each window. The bench measures the phase lengths at the pins, so a zero-as-one or doubling fault shows up apart from a decode or chip-select mapping fault. In this sweep the ready line is held low for several strobe cycles to show that it is ignored. A second sweep enables ready on two windows with wait lengths below, at and above the programmed count; this separates "counter first" from "ready first" ending. The read data model adds the active-cycle index to an address hash, so capturing the data in any cycle other than the last is detected. Addresses just outside each window check the error path, and a configuration write made during an access checks that timing words are latched when the access is accepted.

// File: rtl/xbz_pkg.sv
package xbz_pkg;

  localparam int NUM_ZONES = 5;
  localparam int CS_PINS   = 3;
  localparam int ZONE_W    = $clog2(NUM_ZONES);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ACT,
    PH_TRAIL,
    PH_DONE
  } phase_t;

  // window base address, indexed 0..NUM_ZONES-1
  function automatic logic [31:0] zone_base(input int idx);
    case (idx)
      0:       return 32'h0000_2000;
      1:       return 32'h0000_4000;
      2:       return 32'h0008_0000;
      3:       return 32'h0010_0000;
      default: return 32'h003F_C000;
    endcase
  endfunction

  // window size in words
  function automatic logic [31:0] zone_words(input int idx);
    case (idx)
      0, 1:    return 32'h0000_2000;
      2, 3:    return 32'h0008_0000;
      default: return 32'h0000_4000;
    endcase
  endfunction

  // chip-select pin shared by the window
  function automatic int zone_pin(input int idx);
    case (idx)
      0, 1:    return 0;
      2:       return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/xbz_zone_decode.sv
module xbz_zone_decode
  import xbz_pkg::*;
#(
  parameter int CORE_AW = 24,
  parameter int EXT_AW  = 19
) (
  input  logic [CORE_AW-1:0] addr,
  output logic               hit,
  output logic [ZONE_W-1:0]  zone,
  output logic [EXT_AW-1:0]  offset,
  output logic [CS_PINS-1:0] cs_sel
);

  logic [31:0]             a32;
  logic [NUM_ZONES-1:0]    hit_vec;
  logic [EXT_AW-1:0]       off_vec [NUM_ZONES];

  assign a32 = {{(32-CORE_AW){1'b0}}, addr};

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_win
    localparam logic [31:0] BASE = zone_base(z);
    localparam logic [31:0] LAST = zone_base(z) + zone_words(z) - 32'd1;
    assign hit_vec[z] = (a32 >= BASE) && (a32 <= LAST);
    // window sizes never exceed 2**EXT_AW, so the low bits give the offset
    assign off_vec[z] = addr[EXT_AW-1:0] - BASE[EXT_AW-1:0];
  end

  always_comb begin
    hit    = |hit_vec;
    zone   = '0;
    offset = '0;
    cs_sel = '0;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (hit_vec[z]) begin
        zone              = ZONE_W'(z);
        offset            = off_vec[z];
        cs_sel[zone_pin(z)] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xbz_timing_regs.sv
module xbz_timing_regs
  import xbz_pkg::*;
#(
  parameter int               CFG_W   = 9,
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ZONE_W-1:0] idx,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  rd_data,
  input  logic [ZONE_W-1:0] sel_idx,
  output logic [CFG_W-1:0]  sel_cfg
);

  logic [CFG_W-1:0] mem [NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[z] <= RST_VAL;
      end else if (wr_en && (idx == ZONE_W'(z))) begin
        mem[z] <= wr_data;
      end
    end
  end

  always_comb begin
    sel_cfg = '0;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (sel_idx == ZONE_W'(z)) sel_cfg = mem[z];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int z = 0; z < NUM_ZONES; z++) begin
        if (idx == ZONE_W'(z)) rd_data <= mem[z];
      end
    end
  end

endmodule

// File: rtl/xbz_strobe_seq.sv
module xbz_strobe_seq
  import xbz_pkg::*;
#(
  parameter int EXT_AW  = 19,
  parameter int DATA_W  = 16,
  parameter int LEAD_W  = 2,
  parameter int ACT_W   = 3,
  parameter int TRAIL_W = 2,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               dec_hit,
  input  logic [EXT_AW-1:0]  dec_offset,
  input  logic [CS_PINS-1:0] dec_cs_sel,
  input  logic [LEAD_W-1:0]  lead_f,
  input  logic [ACT_W-1:0]   act_f,
  input  logic [TRAIL_W-1:0] trail_f,
  input  logic               use_rdy,
  input  logic               dbl,
  input  logic               ext_ready,
  input  logic [DATA_W-1:0]  ext_data_i,
  output logic               req_done,
  output logic               req_err,
  output logic [DATA_W-1:0]  req_rdata,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [CS_PINS-1:0] ext_cs_n,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic [DATA_W-1:0]  ext_data_o,
  output logic               ext_data_oe
);

  function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] f, input logic x2);
    logic [CNT_W-1:0] v;
    v = (f == '0) ? CNT_W'(1) : f;
    if (x2) v = v << 1;
    return v - CNT_W'(1);
  endfunction

  phase_t             state, nxt;
  logic [CNT_W-1:0]   cnt, cnt_d;
  logic [CNT_W-1:0]   act_m1, trail_m1;
  logic               rdy_q, wr_q;
  logic [CS_PINS-1:0] cs_q;
  logic               accept, wr_now, in_cycle;
  logic [CS_PINS-1:0] cs_now;

  assign accept = (state == PH_IDLE) && req_valid && dec_hit;
  assign wr_now = (state == PH_IDLE) ? req_write : wr_q;
  assign cs_now = (state == PH_IDLE) ? dec_cs_sel : cs_q;

  always_comb begin
    nxt   = state;
    cnt_d = cnt;
    case (state)
      PH_IDLE: begin
        if (req_valid) begin
          if (!dec_hit) begin
            nxt = PH_DONE;
          end else begin
            nxt   = PH_LEAD;
            cnt_d = span_m1(CNT_W'(lead_f), dbl);
          end
        end
      end
      PH_LEAD: begin
        if (cnt == '0) begin
          nxt   = PH_ACT;
          cnt_d = act_m1;
        end else begin
          cnt_d = cnt - CNT_W'(1);
        end
      end
      PH_ACT: begin
        if (cnt != '0) begin
          cnt_d = cnt - CNT_W'(1);
        end else if (!rdy_q || ext_ready) begin
          nxt   = PH_TRAIL;
          cnt_d = trail_m1;
        end
      end
      PH_TRAIL: begin
        if (cnt == '0) nxt = PH_DONE;
        else           cnt_d = cnt - CNT_W'(1);
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign in_cycle = (nxt == PH_LEAD) || (nxt == PH_ACT) || (nxt == PH_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      cnt         <= '0;
      act_m1      <= '0;
      trail_m1    <= '0;
      rdy_q       <= 1'b0;
      wr_q        <= 1'b0;
      cs_q        <= '0;
      req_done    <= 1'b0;
      req_err     <= 1'b0;
      req_rdata   <= '0;
      ext_addr    <= '0;
      ext_cs_n    <= '1;
      ext_rd_n    <= 1'b1;
      ext_wr_n    <= 1'b1;
      ext_data_o  <= '0;
      ext_data_oe <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_d;
      if (accept) begin
        act_m1     <= span_m1(CNT_W'(act_f), dbl);
        trail_m1   <= span_m1(CNT_W'(trail_f), dbl);
        rdy_q      <= use_rdy;
        wr_q       <= req_write;
        cs_q       <= dec_cs_sel;
        ext_addr   <= dec_offset;
        ext_data_o <= req_wdata;
      end
      if ((state == PH_ACT) && (nxt == PH_TRAIL) && !wr_q) begin
        req_rdata <= ext_data_i;
      end
      ext_cs_n    <= in_cycle ? ~cs_now : '1;
      ext_rd_n    <= !((nxt == PH_ACT) && !wr_now);
      ext_wr_n    <= !((nxt == PH_ACT) && wr_now);
      ext_data_oe <= ((nxt == PH_ACT) || (nxt == PH_TRAIL)) && wr_now;
      req_done    <= (nxt == PH_DONE);
      req_err     <= (state == PH_IDLE) && (nxt == PH_DONE);
    end
  end

endmodule

// File: rtl/xbz_bus_master.sv
module xbz_bus_master
  import xbz_pkg::*;
#(
  parameter int CORE_AW   = 24,
  parameter int EXT_AW    = 19,
  parameter int DATA_W    = 16,
  parameter int LEAD_W    = 2,
  parameter int ACT_W     = 3,
  parameter int TRAIL_W   = 2,
  parameter int RST_LEAD  = 2,
  parameter int RST_ACT   = 3,
  parameter int RST_TRAIL = 1,
  localparam int LEAD_LSB  = 0,
  localparam int ACT_LSB   = LEAD_W,
  localparam int TRAIL_LSB = LEAD_W + ACT_W,
  localparam int RDY_BIT   = TRAIL_LSB + TRAIL_W,
  localparam int DBL_BIT   = RDY_BIT + 1,
  localparam int CFG_W     = DBL_BIT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [CORE_AW-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_done,
  output logic               req_err,
  output logic [DATA_W-1:0]  req_rdata,
  input  logic               cfg_en,
  input  logic [ZONE_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [CS_PINS-1:0] ext_cs_n,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic [DATA_W-1:0]  ext_data_o,
  output logic               ext_data_oe,
  input  logic [DATA_W-1:0]  ext_data_i,
  input  logic               ext_ready
);

  localparam int MAX_W = (ACT_W > LEAD_W) ? ((ACT_W > TRAIL_W) ? ACT_W : TRAIL_W)
                                          : ((LEAD_W > TRAIL_W) ? LEAD_W : TRAIL_W);
  localparam int CNT_W = MAX_W + 1;
  localparam logic [CFG_W-1:0] RST_CFG =
      (CFG_W'(RST_LEAD) << LEAD_LSB) | (CFG_W'(RST_ACT) << ACT_LSB) |
      (CFG_W'(RST_TRAIL) << TRAIL_LSB);

  logic               dec_hit;
  logic [ZONE_W-1:0]  dec_zone;
  logic [EXT_AW-1:0]  dec_offset;
  logic [CS_PINS-1:0] dec_cs_sel;
  logic [CFG_W-1:0]   zone_cfg;

  xbz_zone_decode #(
    .CORE_AW (CORE_AW),
    .EXT_AW  (EXT_AW)
  ) dec_i (
    .addr   (req_addr),
    .hit    (dec_hit),
    .zone   (dec_zone),
    .offset (dec_offset),
    .cs_sel (dec_cs_sel)
  );

  xbz_timing_regs #(
    .CFG_W   (CFG_W),
    .RST_VAL (RST_CFG)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_en),
    .idx     (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .sel_idx (dec_zone),
    .sel_cfg (zone_cfg)
  );

  xbz_strobe_seq #(
    .EXT_AW  (EXT_AW),
    .DATA_W  (DATA_W),
    .LEAD_W  (LEAD_W),
    .ACT_W   (ACT_W),
    .TRAIL_W (TRAIL_W),
    .CNT_W   (CNT_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .dec_hit     (dec_hit),
    .dec_offset  (dec_offset),
    .dec_cs_sel  (dec_cs_sel),
    .lead_f      (zone_cfg[LEAD_LSB +: LEAD_W]),
    .act_f       (zone_cfg[ACT_LSB +: ACT_W]),
    .trail_f     (zone_cfg[TRAIL_LSB +: TRAIL_W]),
    .use_rdy     (zone_cfg[RDY_BIT]),
    .dbl         (zone_cfg[DBL_BIT]),
    .ext_ready   (ext_ready),
    .ext_data_i  (ext_data_i),
    .req_done    (req_done),
    .req_err     (req_err),
    .req_rdata   (req_rdata),
    .ext_addr    (ext_addr),
    .ext_cs_n    (ext_cs_n),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_data_o  (ext_data_o),
    .ext_data_oe (ext_data_oe)
  );

endmodule

// File: rtl/xbz_bus_checker.sv
module xbz_bus_checker
  import xbz_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_done,
  input logic               req_err,
  input logic [CS_PINS-1:0] ext_cs_n,
  input logic               ext_rd_n,
  input logic               ext_wr_n,
  input logic               ext_data_oe
);

  a_r9_single_cs: assert property (@(posedge clk) disable iff (rst)
    $countones(~ext_cs_n) <= 1);

  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r9_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> (ext_cs_n != '1));

  a_r6_oe_write_only: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> ((ext_cs_n != '1) && ext_rd_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  a_r8_done_cs_idle: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (ext_cs_n == '1));

  a_r2_err_with_done: assert property (@(posedge clk) disable iff (rst)
    req_err |-> req_done);

  a_r3_lead_first: assert property (@(posedge clk) disable iff (rst)
    ((ext_cs_n != '1) && ($past(ext_cs_n) == '1)) |-> (ext_rd_n && ext_wr_n && !ext_data_oe));

endmodule

bind xbz_bus_master xbz_bus_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_done    (req_done),
  .req_err     (req_err),
  .ext_cs_n    (ext_cs_n),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .ext_data_oe (ext_data_oe)
);

// File: tb/xbz_bus_master_tb_top.sv
module xbz_bus_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_done, req_err;
  logic [15:0] req_rdata;
  logic        cfg_en = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [8:0]  cfg_wdata = '0;
  logic [8:0]  cfg_rdata;
  logic [18:0] ext_addr;
  logic [2:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n, ext_data_oe;
  logic [15:0] ext_data_o;
  logic [15:0] ext_data_i = '0;
  logic        ext_ready = 1'b0;

  int n_total = 0;
  int n_fail  = 0;
  logic [8:0] cfg_model [5];

  always #5 clk = ~clk;

  xbz_bus_master dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_err(req_err),
    .req_rdata(req_rdata), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_addr(ext_addr),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe),
    .ext_data_i(ext_data_i), .ext_ready(ext_ready)
  );

  function automatic logic [23:0] win_base(int z);
    case (z) 0: return 24'h002000; 1: return 24'h004000; 2: return 24'h080000;
      3: return 24'h100000; default: return 24'h3FC000; endcase
  endfunction
  function automatic int win_size(int z);
    case (z) 0, 1: return 'h2000; 2, 3: return 'h80000; default: return 'h4000; endcase
  endfunction
  function automatic int win_pin(int z);
    case (z) 0, 1: return 0; 2: return 1; default: return 2; endcase
  endfunction
  function automatic logic [8:0] pack(int l, int a, int t, int r, int d);
    return 9'(l) | (9'(a) << 2) | (9'(t) << 5) | (9'(r) << 7) | (9'(d) << 8);
  endfunction
  function automatic int span(int f, int d);
    return ((f == 0) ? 1 : f) * ((d != 0) ? 2 : 1);
  endfunction
  function automatic logic [15:0] hash(logic [18:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(bit ok, string rq, string what, longint got, longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic cfg_write(int z, logic [8:0] v);
    @(negedge clk);
    cfg_en = 1'b1; cfg_idx = 3'(z); cfg_wdata = v;
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_model[z] = v;
  endtask

  task automatic cfg_check(int z, logic [8:0] exp, string rq);
    @(negedge clk);
    cfg_idx = 3'(z);
    @(negedge clk);
    check(cfg_rdata == exp, rq, "timing word readback", cfg_rdata, exp);
  endtask

  // z < 0 means the address lies in no window; wait_w = ready-low active cycles
  task automatic access(logic [23:0] a, bit wr, logic [15:0] wd, int z, int wait_w);
    int lc, ac, tc, cyc, el, ea, et, pin;
    logic [8:0] c;
    logic [18:0] off;
    bit bad_addr, bad_cs, bad_oe, bad_dat, cs_seen, got_err;
    logic [15:0] got_rd, exp_rd;
    lc = 0; ac = 0; tc = 0; cyc = 0;
    bad_addr = 0; bad_cs = 0; bad_oe = 0; bad_dat = 0; cs_seen = 0; got_err = 0;
    got_rd = '0;
    el = 0; ea = 0; et = 0; pin = 0; off = '0;
    if (z >= 0) begin
      c   = cfg_model[z];
      el  = span(int'(c[1:0]), int'(c[8]));
      ea  = span(int'(c[4:2]), int'(c[8]));
      et  = span(int'(c[6:5]), int'(c[8]));
      if (c[7] && (wait_w + 1 > ea)) ea = wait_w + 1;
      pin = win_pin(z);
      off = 19'(a - win_base(z));
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 400) begin
        check(1'b0, "R8", "access timeout", cyc, 0);
        break;
      end
      if (req_done) begin
        got_err = req_err;
        got_rd  = req_rdata;
        if (ext_cs_n != 3'b111) bad_cs = 1;
        req_valid = 1'b0;
        ext_ready = 1'b0;
        break;
      end
      if (ext_cs_n != 3'b111) begin
        cs_seen = 1;
        if (ext_cs_n != ~(3'b001 << pin)) bad_cs = 1;
        if (ext_addr != off) bad_addr = 1;
        if (!ext_rd_n || !ext_wr_n) begin
          if (wr && (ext_wr_n || !ext_rd_n)) bad_dat = 1;
          if (!wr && (ext_rd_n || !ext_wr_n)) bad_dat = 1;
          if (ext_data_oe != wr) bad_oe = 1;
          if (wr && ext_data_o != wd) bad_dat = 1;
          ext_data_i = hash(ext_addr) + 16'(ac);
          ext_ready  = (ac >= wait_w);
          ac++;
        end else begin
          ext_ready = 1'b0;
          if (ac == 0) begin
            lc++;
            if (ext_data_oe) bad_oe = 1;
          end else begin
            tc++;
            if (ext_data_oe != wr) bad_oe = 1;
            if (wr && ext_data_o != wd) bad_dat = 1;
          end
        end
      end else if (lc + ac + tc > 0) begin
        bad_cs = 1;
      end
    end
    if (z < 0) begin
      check(got_err == 1'b1, "R2", "error flag", got_err, 1);
      check(!cs_seen, "R2", "no chip select on miss", cs_seen, 0);
    end else begin
      check(got_err == 1'b0, "R1", "error flag on hit", got_err, 0);
      check(!bad_cs, "R1", "chip-select pin", ext_cs_n, pin);
      check(!bad_addr, "R1", "window offset", 0, off);
      check(lc == el, c[8] ? "R4" : "R3", "lead cycles", lc, el);
      check(ac == ea, c[7] ? "R5" : "R3", "active cycles", ac, ea);
      check(tc == et, c[8] ? "R4" : "R3", "trail cycles", tc, et);
      check(!bad_oe, "R6", "data enable window", bad_oe, 0);
      if (wr) check(!bad_dat, "R6", "write strobe/data", bad_dat, 0);
      else begin
        exp_rd = hash(off) + 16'(ea - 1);
        check(got_rd == exp_rd, "R7", "read data", got_rd, exp_rd);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL R8 watchdog expired: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

  initial begin
    int k;
    logic [23:0] a;
    for (int z = 0; z < 5; z++) cfg_model[z] = 9'h02E;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(ext_cs_n == 3'b111, "R11", "reset chip selects", ext_cs_n, 7);
    check(ext_rd_n && ext_wr_n, "R11", "reset strobes", {ext_rd_n, ext_wr_n}, 3);
    check(!ext_data_oe && !req_done, "R11", "reset enable/done", {ext_data_oe, req_done}, 0);
    for (int z = 0; z < 5; z++) cfg_check(z, 9'h02E, "R11");

    // R10 write and readback
    cfg_write(1, 9'h1A5);
    cfg_check(1, 9'h1A5, "R10");
    cfg_check(0, 9'h02E, "R10");

    // R1/R3/R4/R6/R7 sweep; ready held low 3 active cycles and ignored (R5)
    k = 0;
    for (int z = 0; z < 5; z++)
      for (int l = 0; l < 4; l += (l == 1) ? 2 : 1)
        for (int ai = 0; ai < 3; ai++)
          for (int t = 1; t < 4; t += 2)
            for (int d = 0; d < 2; d++)
              for (int w = 0; w < 2; w++) begin
                int av;
                av = (ai == 0) ? 0 : ((ai == 1) ? 2 : 7);
                if (l == 2) continue;
                cfg_write(z, pack(l, av, t, 0, d));
                case (k % 3)
                  0: a = win_base(z);
                  1: a = win_base(z) + 24'(win_size(z) - 1);
                  default: a = win_base(z) + 24'((k * 37) % win_size(z));
                endcase
                access(a, w[0], 16'(16'h1234 + k * 77), z, 3);
                k++;
              end

    // R5 ready enabled on windows 2 and 4
    for (int zi = 0; zi < 2; zi++)
      for (int ai = 1; ai < 4; ai += 2)
        for (int wi = 0; wi < 4; wi++)
          for (int w = 0; w < 2; w++) begin
            int z, ww;
            z  = (zi == 0) ? 2 : 4;
            ww = (wi == 0) ? 0 : ((wi == 1) ? 1 : ((wi == 2) ? 3 : 8));
            cfg_write(z, pack(1, ai, 1, 1, 0));
            access(win_base(z) + 24'(ww * 5), w[0], 16'(16'hBEEF ^ ww), z, ww);
          end

    // R2 misses just outside windows
    access(24'h000000, 1'b0, 16'h0, -1, 0);
    access(24'h001FFF, 1'b1, 16'h1, -1, 0);
    access(24'h006000, 1'b0, 16'h0, -1, 0);
    access(24'h07FFFF, 1'b1, 16'h2, -1, 0);
    access(24'h180000, 1'b0, 16'h0, -1, 0);
    access(24'h3FBFFF, 1'b1, 16'h3, -1, 0);
    access(24'h400000, 1'b0, 16'h0, -1, 0);
    access(24'hFFFFFF, 1'b1, 16'h4, -1, 0);

    // R10 timing word latched at accept
    cfg_write(0, pack(1, 2, 1, 0, 0));
    fork
      access(24'h002010, 1'b0, 16'h0, 0, 0);
      begin
        repeat (3) @(negedge clk);
        cfg_en = 1'b1; cfg_idx = 3'd0; cfg_wdata = pack(3, 5, 3, 0, 0);
        @(negedge clk);
        cfg_en = 1'b0;
      end
    join
    cfg_model[0] = pack(3, 5, 3, 0, 0);
    access(24'h002011, 1'b1, 16'h5A5A, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

endmodule